// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler

This block guards a processor against runaway software. A slow, free-running watchdog clock is brought into the system clock domain, and each of its rising edges advances a counter chain: a fixed 6-bit front divider followed by a 7-bit prescaler. A 3-bit rate field in a small control register picks the prescaler tap, so the timeout period runs from 64 up to 8192 watchdog ticks. Software restarts the count with a clear-watchdog instruction pulse. A halt instruction pulse restarts it as well.

The effect of a timeout depends on the core's mode. While the core is awake, a timeout raises a one-cycle device-reset request. While the core is asleep, it raises only a one-cycle wake-up request, which restarts the program counter and stack. A sleep-mode timeout counts only when the pointer-is-zero qualifier is high. In every case that counts, a sticky timeout status bit is set. A configuration enable turns the whole function off, and a reserved code in the control register stops counting from software.

The controller is a five-state machine:
- `ST_STOPPED`: not counting.
- `ST_AWAKE`: counting in run mode.
- `ST_ASLEEP`: counting in sleep mode.
- `ST_FIRE_RST`: one cycle of reset request.
- `ST_FIRE_WAKE`: one cycle of wake-up request.

Its transitions are:
- STOPPED to AWAKE or ASLEEP when the counter becomes active, chosen by the sleep input.
- AWAKE and ASLEEP swap when the sleep input changes.
- AWAKE to FIRE_RST on an overflow.
- ASLEEP to FIRE_WAKE on an overflow while pointer-is-zero is high.
- Either FIRE state back to AWAKE, ASLEEP or STOPPED on the next cycle.
- Any counting state to STOPPED when the counter becomes inactive.

Top module: `wdog_timer`

## Requirements
- R1: While `rst_n` is low, `rst_req`, `wake_req` and `to_flag` are 0 and the counters are zero. The control register resets to rate 7 with counting allowed.
- R2: With rate field n in `ctl_wdata[2:0]`, a timeout happens on exactly the 2^(6+n)-th watchdog tick after the count last restarted. Every timeout restarts the count from zero.
- R3: A `clr_wdt` pulse while `cfg_en` is high restarts the count from zero.
- R4: A `halt` pulse restarts the count from zero.
- R5: A timeout while the core is awake drives `rst_req` high for exactly one system-clock cycle and sets `to_flag`.
- R6: A timeout while `sleep` is high and `ptr_zero` is high drives `wake_req` high for exactly one cycle and sets `to_flag`, with no `rst_req`.
- R7: A timeout while `sleep` is high and `ptr_zero` is low produces no `wake_req`, no `rst_req`, and leaves `to_flag` unchanged.
- R8: While `cfg_en` is low, nothing counts and no timeout occurs. A `clr_wdt` pulse is ignored then, including as a source for clearing the status bit.
- R9: Writing the code 4'b0101 into `ctl_wdata[6:3]` stops counting and holds the counter at zero. Writing any other code resumes counting from zero.
- R10: `to_flag` stays set until `sts_clr` is high in the same cycle as an accepted clear (`clr_wdt` with `cfg_en`, or `halt`). Setting wins over clearing.
- R11: Each rising edge of `wdt_clk` is counted exactly once, whatever its high time, provided the high and low phases each last at least one system-clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| wdt_clk | input | 1 | Slow watchdog clock, asynchronous to `clk` |
| cfg_en | input | 1 | Configuration enable for the watchdog function |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 7 | Control value: [6:3] disable code, [2:0] rate select |
| clr_wdt | input | 1 | Clear-watchdog instruction pulse |
| halt | input | 1 | Halt instruction pulse |
| sts_clr | input | 1 | Status-clear strobe, acts together with a clear or halt |
| sleep | input | 1 | Core is in sleep mode |
| ptr_zero | input | 1 | Pointer-is-zero qualifier for sleep-mode overflow |
| rst_req | output | 1 | One-cycle device-reset request |
| wake_req | output | 1 | One-cycle wake-up request |
| to_flag | output | 1 | Sticky timeout status |

## Verification
Every rate value from 7 down to 0 is swept. For each, the bench applies one tick fewer than the expected period and then the final tick, which tells an off-by-one tap apart from the correct one. The watchdog clock's high time is varied across the sweep, which separates true edge detection from level counting. The clear, halt, software-disable and configuration-off cases each restart or freeze the count partway through a period. A later full period then shows whether the counter really returned to zero. Sleep with the qualifier high and with it low is tried against run mode, which separates a wake-up from a reset request and from a suppressed overflow.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [2:0] {
        ST_STOPPED   = 3'd0,
        ST_AWAKE     = 3'd1,
        ST_ASLEEP    = 3'd2,
        ST_FIRE_RST  = 3'd3,
        ST_FIRE_WAKE = 3'd4
    } wdog_state_e;

    localparam int unsigned WDOG_CODE_W = 4;
    localparam logic [WDOG_CODE_W-1:0] WDOG_OFF_CODE = 4'b0101;

endpackage

// File: rtl/wdog_tick_sync.sv
module wdog_tick_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_clk,
    output logic tick
);
    localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], slow_clk};
        end
    end

    assign tick = chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];

    // R11: a detected edge lasts one cycle
    p_tick_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/wdog_divider.sv
module wdog_divider #(
    parameter int unsigned STAGE_A = 6,
    parameter int unsigned STAGE_B = 7,
    parameter int unsigned SEL_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             clear,
    input  logic [SEL_W-1:0] sel,
    output logic             ovf
);
    localparam int unsigned TOT_W = STAGE_A + STAGE_B;
    localparam logic [TOT_W-1:0] TOT_ONE = TOT_W'(1);

    logic [STAGE_A-1:0] front_q;
    logic [STAGE_B-1:0] pre_q;
    logic [TOT_W-1:0]   tap_mask;
    logic               front_full;

    always_comb begin
        tap_mask = (TOT_ONE << (STAGE_A + int'(sel))) - TOT_ONE;
    end

    assign front_full = &front_q;
    assign ovf = tick & en & ~clear & (({pre_q, front_q} & tap_mask) == tap_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            front_q <= '0;
            pre_q   <= '0;
        end else if (!en || clear || ovf) begin
            front_q <= '0;
            pre_q   <= '0;
        end else if (tick) begin
            front_q <= front_q + 1'b1;
            if (front_full) begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    // R9: disabled counter holds zero
    p_hold_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ({pre_q, front_q} == '0));
    // R3: an accepted clear empties both stages
    p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> ({pre_q, front_q} == '0));
    // R2: overflow restarts the count
    p_ovf_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ({pre_q, front_q} == '0));

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic sleep,
    input  logic ptr_zero,
    input  logic ovf,
    input  logic clr_ok,
    input  logic sts_clr,
    output logic rst_req,
    output logic wake_req,
    output logic to_flag
);
    wdog_state_e state_q, state_d;
    logic        fire_start;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: begin
                if (active) state_d = sleep ? ST_ASLEEP : ST_AWAKE;
            end
            ST_AWAKE: begin
                if (!active)    state_d = ST_STOPPED;
                else if (ovf)   state_d = ST_FIRE_RST;
                else if (sleep) state_d = ST_ASLEEP;
            end
            ST_ASLEEP: begin
                if (!active)             state_d = ST_STOPPED;
                else if (ovf && ptr_zero) state_d = ST_FIRE_WAKE;
                else if (!sleep)         state_d = ST_AWAKE;
            end
            ST_FIRE_RST, ST_FIRE_WAKE: begin
                if (!active) state_d = ST_STOPPED;
                else         state_d = sleep ? ST_ASLEEP : ST_AWAKE;
            end
            default: state_d = ST_STOPPED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    always_comb begin
        rst_req  = (state_q == ST_FIRE_RST);
        wake_req = (state_q == ST_FIRE_WAKE);
    end

    assign fire_start = (state_d == ST_FIRE_RST || state_d == ST_FIRE_WAKE)
                        && !(state_q == ST_FIRE_RST || state_q == ST_FIRE_WAKE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  to_flag <= 1'b0;
        else if (fire_start)         to_flag <= 1'b1;
        else if (sts_clr && clr_ok)  to_flag <= 1'b0;
    end

    // R5: reset request is a single cycle
    p_rst_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    // R6: wake request is a single cycle
    p_wake_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> !wake_req);
    // R6: sleep-mode overflow never resets the device
    p_sleep_no_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ASLEEP && ovf) |=> !rst_req);
    // R7: qualifier low suppresses the wake
    p_sleep_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ASLEEP && ovf && !ptr_zero) |=> !wake_req);
    // R10: any request comes with the status bit
    p_flag_with_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || wake_req) |-> to_flag);
    // R10: status holds without an accepted clear
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (to_flag && !(sts_clr && clr_ok)) |=> to_flag);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int unsigned STAGE_A = 6,
    parameter int unsigned STAGE_B = 7,
    parameter int unsigned SEL_W   = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wdt_clk,
    input  logic                           cfg_en,
    input  logic                           ctl_we,
    input  logic [WDOG_CODE_W+SEL_W-1:0]   ctl_wdata,
    input  logic                           clr_wdt,
    input  logic                           halt,
    input  logic                           sts_clr,
    input  logic                           sleep,
    input  logic                           ptr_zero,
    output logic                           rst_req,
    output logic                           wake_req,
    output logic                           to_flag
);
    localparam logic [SEL_W-1:0] RATE_RESET = SEL_W'(STAGE_B);

    logic [SEL_W-1:0] rate_q;
    logic             soft_off_q;
    logic             tick;
    logic             cnt_en;
    logic             clr_ok;
    logic             ovf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q     <= RATE_RESET;
            soft_off_q <= 1'b0;
        end else if (ctl_we) begin
            rate_q     <= ctl_wdata[SEL_W-1:0];
            soft_off_q <= (ctl_wdata[WDOG_CODE_W+SEL_W-1:SEL_W] == WDOG_OFF_CODE);
        end
    end

    assign cnt_en = cfg_en & ~soft_off_q;
    assign clr_ok = halt | (cfg_en & clr_wdt);

    wdog_tick_sync #(.SYNC_STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .slow_clk (wdt_clk),
        .tick     (tick)
    );

    wdog_divider #(
        .STAGE_A (STAGE_A),
        .STAGE_B (STAGE_B),
        .SEL_W   (SEL_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .en    (cnt_en),
        .clear (clr_ok),
        .sel   (rate_q),
        .ovf   (ovf)
    );

    wdog_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (cnt_en),
        .sleep    (sleep),
        .ptr_zero (ptr_zero),
        .ovf      (ovf),
        .clr_ok   (clr_ok),
        .sts_clr  (sts_clr),
        .rst_req  (rst_req),
        .wake_req (wake_req),
        .to_flag  (to_flag)
    );

    // R8: with the function off no request appears
    p_cfg_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !$past(cfg_en)) |-> !(rst_req || wake_req));

endmodule

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wdt_clk = 1'b0;
    logic       cfg_en = 1'b1;
    logic       ctl_we = 1'b0;
    logic [6:0] ctl_wdata = '0;
    logic       clr_wdt = 1'b0;
    logic       halt = 1'b0;
    logic       sts_clr = 1'b0;
    logic       sleep = 1'b0;
    logic       ptr_zero = 1'b0;
    logic       rst_req, wake_req, to_flag;

    int errors = 0;
    int checks = 0;
    int rst_hi = 0, rst_rise = 0, wake_hi = 0, wake_rise = 0;
    logic rst_prev = 1'b0, wake_prev = 1'b0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdog_timer u_wdog_timer (
        .clk(clk), .rst_n(rst_n), .wdt_clk(wdt_clk), .cfg_en(cfg_en),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .clr_wdt(clr_wdt),
        .halt(halt), .sts_clr(sts_clr), .sleep(sleep), .ptr_zero(ptr_zero),
        .rst_req(rst_req), .wake_req(wake_req), .to_flag(to_flag)
    );

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (rst_req) rst_hi <= rst_hi + 1;
        if (wake_req) wake_hi <= wake_hi + 1;
        if (rst_req && !rst_prev) rst_rise <= rst_rise + 1;
        if (wake_req && !wake_prev) wake_rise <= wake_rise + 1;
        rst_prev <= rst_req;
        wake_prev <= wake_req;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic edges(input int k, input int hi);
        for (int i = 0; i < k; i++) begin
            @(negedge clk) wdt_clk = 1'b1;
            repeat (hi) @(negedge clk);
            wdt_clk = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic do_clr(input bit sc);
        @(negedge clk) begin clr_wdt = 1'b1; sts_clr = sc; end
        @(negedge clk) begin clr_wdt = 1'b0; sts_clr = 1'b0; end
    endtask

    task automatic do_halt(input bit sc);
        @(negedge clk) begin halt = 1'b1; sts_clr = sc; end
        @(negedge clk) begin halt = 1'b0; sts_clr = 1'b0; end
    endtask

    task automatic wr_ctl(input logic [3:0] code, input logic [2:0] rate);
        @(negedge clk) begin ctl_we = 1'b1; ctl_wdata = {code, rate}; end
        @(negedge clk) ctl_we = 1'b0;
    endtask

    initial begin
        while (!done && cycles < 190000) @(negedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=0 (cycles left)", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int b;
        repeat (5) @(negedge clk);
        chk("R1 rst_req in reset", int'(rst_req), 0);
        chk("R1 to_flag in reset", int'(to_flag), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 wake_req after reset", int'(wake_req), 0);

        // R2/R5/R11 sweep: rate 7 uses the reset default (R1)
        for (int n = 7; n >= 0; n--) begin
            int per;
            int hi;
            per = 1 << (6 + n);
            hi = 1 + (n % 3);
            if (n != 7) wr_ctl(4'b0000, 3'(n));
            do_clr(1'b1);
            b = rst_rise;
            edges(per - 1, hi);
            chk($sformatf("R2 rate %0d one tick short", n), rst_rise - b, 0);
            chk($sformatf("R11 rate %0d flag quiet", n), int'(to_flag), 0);
            edges(1, hi);
            chk($sformatf("R2 rate %0d timeout", n), rst_rise - b, 1);
            chk($sformatf("R5 rate %0d flag set", n), int'(to_flag), 1);
        end
        chk("R5 reset pulse width", rst_hi, rst_rise);
        chk("R5 no wake in run mode", wake_rise, 0);

        // rate 0 from here: 64 ticks
        do_clr(1'b0);
        chk("R10 clear without strobe keeps flag", int'(to_flag), 1);
        @(negedge clk) sts_clr = 1'b1;
        @(negedge clk) sts_clr = 1'b0;
        chk("R10 strobe alone keeps flag", int'(to_flag), 1);
        do_clr(1'b1);
        chk("R10 strobe with clear drops flag", int'(to_flag), 0);

        // R3 clear restarts count
        b = rst_rise;
        edges(63, 1);
        do_clr(1'b0);
        edges(63, 2);
        chk("R3 clear restarted count", rst_rise - b, 0);
        edges(1, 1);
        chk("R3 full period after clear", rst_rise - b, 1);

        // R4 halt restarts count, R10 halt clears flag
        do_halt(1'b1);
        chk("R10 halt with strobe drops flag", int'(to_flag), 0);
        b = rst_rise;
        edges(50, 1);
        do_halt(1'b0);
        edges(63, 1);
        chk("R4 halt restarted count", rst_rise - b, 0);
        edges(1, 1);
        chk("R4 full period after halt", rst_rise - b, 1);
        do_halt(1'b1);

        // R6 sleep with qualifier
        sleep = 1'b1; ptr_zero = 1'b1;
        do_halt(1'b0);
        b = rst_rise;
        edges(64, 1);
        chk("R6 wake issued", wake_rise, 1);
        chk("R6 no reset in sleep", rst_rise - b, 0);
        chk("R6 flag set", int'(to_flag), 1);
        chk("R6 wake pulse width", wake_hi, wake_rise);
        do_halt(1'b1);

        // R7 sleep without qualifier
        ptr_zero = 1'b0;
        do_halt(1'b0);
        edges(64, 1);
        chk("R7 no wake", wake_rise, 1);
        chk("R7 no reset", rst_rise - b, 0);
        chk("R7 flag unchanged", int'(to_flag), 0);
        sleep = 1'b0;

        // R8 configuration off
        do_halt(1'b0);
        edges(64, 1);
        chk("R8 setup flag", int'(to_flag), 1);
        @(negedge clk) cfg_en = 1'b0;
        do_clr(1'b1);
        chk("R8 clear ignored for flag", int'(to_flag), 1);
        b = rst_rise;
        edges(200, 1);
        chk("R8 no timeout while off", rst_rise - b, 0);
        @(negedge clk) cfg_en = 1'b1;
        edges(63, 1);
        chk("R8 count held at zero", rst_rise - b, 0);
        edges(1, 1);
        chk("R8 counting resumes", rst_rise - b, 1);

        // R9 software disable code
        do_halt(1'b1);
        b = rst_rise;
        edges(30, 1);
        wr_ctl(4'b0101, 3'd0);
        edges(100, 1);
        chk("R9 no timeout while disabled", rst_rise - b, 0);
        wr_ctl(4'b0000, 3'd0);
        edges(63, 1);
        chk("R9 resume from zero", rst_rise - b, 0);
        edges(1, 1);
        chk("R9 timeout after resume", rst_rise - b, 1);

        // R1 external reset clears the status
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk("R1 flag cleared by reset", int'(to_flag), 0);
        chk("R1 rst_req low in reset", int'(rst_req), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule